// File: doc/BRIEF.md
# Three-Segment Gamma Table Loader

This block is the write side of a per-pipe gamma correction table that is split into three segments. Software reaches it through a small register bus. For each bank it writes an index register that sets a starting slot and an auto-advance flag. It then streams 32-bit data words into that bank's data register. Every table entry costs two data writes. The first write carries the six least significant bits of each 16-bit colour channel. The second write carries the ten most significant bits. The entry is stored only when the second word arrives.

There are two banks. The superfine bank has 9 slots and covers the very dark end of the curve. The main bank has 512 slots: the fine segment fills slots 0 to 255 and the coarse segment fills slots 256 to 511, both loaded under one index. Three further registers hold the per-channel output used at or beyond full scale. A combinational look-up port lets the neighbouring pixel evaluator read any stored entry. Reading an index register returns the flag and the slot that the next pair will land in.

Top module: `gamma_seg_lut`

## Requirements
- R1: Register word addresses are: 0 superfine index, 1 superfine data, 2 main index, 3 main data, 4 red max, 5 green max, 6 blue max. A read returns its value on `reg_rdata` in the cycle after `reg_rd`, and returns 0 in every other cycle. Reading a data register or address 7 returns 0.
- R2: An entry is assembled from two words. The low word holds red[5:0] at bits 29:24, green[5:0] at bits 19:14 and blue[5:0] at bits 9:4. The high word holds red[15:6] at bits 29:20, green[15:6] at bits 19:10 and blue[15:6] at bits 9:0.
- R3: The first word of a pair leaves both the stored table and the index unchanged. Only the second word writes the entry.
- R4: An index write sets bit 15 as the auto-advance flag and sets the start slot (bits 4:0 for superfine, bits 8:0 for main). With the flag set, every completed pair moves the index up by one. An index read shows the flag at bit 15 and the current slot in the low bits, with all other bits 0.
- R5: With the flag clear, repeated pairs overwrite the same slot and the index does not move.
- R6: Advancing from the last slot of a bank wraps the index to 0. A start slot written at or beyond the bank size becomes 0.
- R7: An index write discards a pending low word, so the next data word is treated as a low word.
- R8: One superfine index write followed by 9 pairs fills superfine slots 0 to 8 in order. One main index write followed by 512 pairs fills the fine slots 0 to 255 and then the coarse slots 256 to 511.
- R9: Each max register stores bits 15:0 of its write and ignores bits 31:16. It drives its own output and reads back its value.
- R10: After reset, both indices are 0, both flags are clear, no low word is pending, and the max registers are 0.
- R11: Writes to one bank leave the other bank's index, flag and entries unchanged.
- R12: The look-up port returns the stored entry of the selected bank (`lk_bank` 0 is superfine, 1 is main), packed as red at bits 47:32, green at 31:16 and blue at 15:0. A superfine slot of 9 or above returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the strobe |
| lk_bank | input | 1 | Look-up bank select |
| lk_idx | input | 9 | Look-up slot |
| lk_rgb | output | 48 | Stored entry at the look-up slot |
| gmax_red | output | 16 | Red full-scale value |
| gmax_green | output | 16 | Green full-scale value |
| gmax_blue | output | 16 | Blue full-scale value |

## Verification
The bench uses the default sizes: a 9-slot superfine bank and a 512-slot main bank. With these sizes, wrap-around from slot 8 and from slot 511 can be reached within a few thousand cycles. Out-of-range superfine start values (9 to 31) fit in the 5-bit field, so they can also be driven. A complete 512-pair load of the main bank is driven so that both the fine and the coarse halves are checked.

// File: rtl/gamma_lut_pkg.sv
`timescale 1ns/1ps
package gamma_lut_pkg;

  localparam int CH_W   = 16;
  localparam int HI_W   = 10;
  localparam int LO_W   = CH_W - HI_W;
  localparam int FLAG_B = 15;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } rgb16_t;

  typedef logic [3*LO_W-1:0] low_part_t;

  // fetch the least significant channel bits from a first word
  function automatic low_part_t take_low(input logic [31:0] w);
    return {w[29:24], w[19:14], w[9:4]};
  endfunction

  // build a full entry from a held low part and a second word
  function automatic rgb16_t merge_pair(input low_part_t lo, input logic [31:0] hi);
    rgb16_t e;
    e.r = {hi[29:20], lo[3*LO_W-1:2*LO_W]};
    e.g = {hi[19:10], lo[2*LO_W-1:LO_W]};
    e.b = {hi[9:0],   lo[LO_W-1:0]};
    return e;
  endfunction

endpackage

// File: rtl/gamma_lut_bank.sv
`timescale 1ns/1ps
module gamma_lut_bank
  import gamma_lut_pkg::*;
#(
  parameter int DEPTH = 9,
  parameter int IW    = 5,
  parameter int LKW   = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            idx_wr,
  input  logic            dat_wr,
  input  logic [31:0]     wdata,
  output logic [31:0]     idx_view,
  output logic            commit_o,
  input  logic [LKW-1:0]  lk_idx,
  output rgb16_t          lk_rgb
);

  logic          auto_q;
  logic          phase_q;
  logic [IW-1:0] idx_q;
  low_part_t     lo_q;
  rgb16_t        mem [DEPTH];

  logic          commit_ev;
  logic          lowcap_ev;
  logic [IW-1:0] idx_next;
  logic [IW-1:0] idx_start;
  logic          wd_unused;

  assign wd_unused = ^wdata[31:30];
  assign commit_ev = dat_wr & phase_q;
  assign lowcap_ev = dat_wr & ~phase_q;
  assign commit_o  = commit_ev;

  assign idx_next  = (int'(idx_q) == DEPTH - 1) ? '0 : idx_q + 1'b1;
  assign idx_start = (int'(wdata[IW-1:0]) >= DEPTH) ? '0 : wdata[IW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      auto_q  <= 1'b0;
      phase_q <= 1'b0;
      idx_q   <= '0;
      lo_q    <= '0;
    end else if (idx_wr) begin
      auto_q  <= wdata[FLAG_B];
      idx_q   <= idx_start;
      phase_q <= 1'b0;
    end else if (lowcap_ev) begin
      lo_q    <= take_low(wdata);
      phase_q <= 1'b1;
    end else if (commit_ev) begin
      phase_q <= 1'b0;
      if (auto_q) idx_q <= idx_next;
    end
  end

  always_ff @(posedge clk) begin
    if (commit_ev) mem[idx_q] <= merge_pair(lo_q, wdata);
  end

  assign idx_view = {16'd0, auto_q, {(15-IW){1'b0}}, idx_q};
  assign lk_rgb   = (int'(lk_idx) < DEPTH) ? mem[lk_idx[IW-1:0]] : '0;

  AST_PHASE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> !phase_q); // R7
  AST_LOW_HOLDS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    lowcap_ev |=> $stable(idx_q)); // R3
  AST_NO_AUTO_STAY: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ev && !auto_q |=> $stable(idx_q)); // R5
  AST_AUTO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ev && auto_q |=>
      int'(idx_q) == ((int'($past(idx_q)) == DEPTH - 1) ? 0 : int'($past(idx_q)) + 1)); // R4
  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(idx_q) < DEPTH); // R6

endmodule

// File: rtl/gamma_max_reg.sv
`timescale 1ns/1ps
module gamma_max_reg
  import gamma_lut_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [31:0]     wdata,
  output logic [CH_W-1:0] q
);

  logic hi_unused;
  assign hi_unused = ^wdata[31:CH_W];

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= wdata[CH_W-1:0];
  end

  AST_MAX_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(q)); // R9

endmodule

// File: rtl/gamma_seg_lut.sv
`timescale 1ns/1ps
module gamma_seg_lut
  import gamma_lut_pkg::*;
#(
  parameter int SF_DEPTH = 9,
  parameter int SF_IW    = 5,
  parameter int FC_DEPTH = 512
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [2:0]                  reg_addr,
  input  logic                        reg_wr,
  input  logic                        reg_rd,
  input  logic [31:0]                 reg_wdata,
  output logic [31:0]                 reg_rdata,
  input  logic                        lk_bank,
  input  logic [$clog2(FC_DEPTH)-1:0] lk_idx,
  output logic [3*CH_W-1:0]           lk_rgb,
  output logic [CH_W-1:0]             gmax_red,
  output logic [CH_W-1:0]             gmax_green,
  output logic [CH_W-1:0]             gmax_blue
);

  localparam int FC_IW  = $clog2(FC_DEPTH);
  localparam int N_MAX  = 3;
  localparam logic [2:0] A_SF_IDX = 3'd0;
  localparam logic [2:0] A_SF_DAT = 3'd1;
  localparam logic [2:0] A_FC_IDX = 3'd2;
  localparam logic [2:0] A_FC_DAT = 3'd3;
  localparam logic [2:0] A_MAX0   = 3'd4;

  logic [31:0]     sf_view, fc_view;
  logic            sf_commit, fc_commit;
  rgb16_t          sf_rgb, fc_rgb;
  logic [CH_W-1:0] max_q [N_MAX];
  logic [31:0]     rd_mux;

  gamma_lut_bank #(.DEPTH(SF_DEPTH), .IW(SF_IW), .LKW(FC_IW)) u_sf (
    .clk(clk), .rst_n(rst_n),
    .idx_wr(reg_wr && reg_addr == A_SF_IDX),
    .dat_wr(reg_wr && reg_addr == A_SF_DAT),
    .wdata(reg_wdata), .idx_view(sf_view), .commit_o(sf_commit),
    .lk_idx(lk_idx), .lk_rgb(sf_rgb));

  gamma_lut_bank #(.DEPTH(FC_DEPTH), .IW(FC_IW), .LKW(FC_IW)) u_fc (
    .clk(clk), .rst_n(rst_n),
    .idx_wr(reg_wr && reg_addr == A_FC_IDX),
    .dat_wr(reg_wr && reg_addr == A_FC_DAT),
    .wdata(reg_wdata), .idx_view(fc_view), .commit_o(fc_commit),
    .lk_idx(lk_idx), .lk_rgb(fc_rgb));

  for (genvar c = 0; c < N_MAX; c++) begin : g_max
    gamma_max_reg u_max (
      .clk(clk), .rst_n(rst_n),
      .wr(reg_wr && reg_addr == A_MAX0 + 3'(c)),
      .wdata(reg_wdata), .q(max_q[c]));
  end

  assign gmax_red   = max_q[0];
  assign gmax_green = max_q[1];
  assign gmax_blue  = max_q[2];
  assign lk_rgb     = lk_bank ? fc_rgb : sf_rgb;

  always_comb begin
    case (reg_addr)
      A_SF_IDX: rd_mux = sf_view;
      A_FC_IDX: rd_mux = fc_view;
      3'd4:     rd_mux = {16'd0, max_q[0]};
      3'd5:     rd_mux = {16'd0, max_q[1]};
      3'd6:     rd_mux = {16'd0, max_q[2]};
      default:  rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
    else             reg_rdata <= '0;
  end

  AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sf_commit, fc_commit})); // R11
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> reg_rdata == 32'd0); // R1

endmodule

// File: tb/sim_gamma_seg_lut.sv
`timescale 1ns/1ps
module sim_gamma_seg_lut;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        lk_bank = 1'b0;
  logic [8:0]  lk_idx = '0;
  logic [47:0] lk_rgb;
  logic [15:0] gmax_red, gmax_green, gmax_blue;

  always #2 clk = ~clk;

  gamma_seg_lut u0 (.*);

  int n_chk = 0, n_fail = 0;

  // bench model
  logic [47:0] m_sf [9];
  logic [47:0] m_fc [512];
  bit          v_sf [9];
  bit          v_fc [512];
  int          sf_i, fc_i;
  bit          sf_a, fc_a, sf_p, fc_p;
  logic [31:0] sf_lo, fc_lo;
  logic [15:0] m_max [3];

  function automatic logic [47:0] expect_rgb(logic [31:0] lo, logic [31:0] hi);
    logic [15:0] r, g, b;
    r = 16'(((hi >> 20) & 32'h3FF) << 6) | 16'((lo >> 24) & 32'h3F);
    g = 16'(((hi >> 10) & 32'h3FF) << 6) | 16'((lo >> 14) & 32'h3F);
    b = 16'((hi & 32'h3FF) << 6)         | 16'((lo >> 4) & 32'h3F);
    return {r, g, b};
  endfunction

  function automatic logic [31:0] word_hi(logic [47:0] e);
    return (32'(e[47:38]) << 20) | (32'(e[31:22]) << 10) | 32'(e[15:6]);
  endfunction

  function automatic logic [31:0] word_lo(logic [47:0] e);
    return (32'(e[37:32]) << 24) | (32'(e[21:16]) << 14) | (32'(e[5:0]) << 4);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwrite(int a, logic [31:0] d);
    @(negedge clk);
    reg_addr = 3'(a); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    case (a)
      0: begin sf_a = d[15]; sf_i = (int'(d[4:0]) >= 9) ? 0 : int'(d[4:0]); sf_p = 0; end
      1: if (!sf_p) begin sf_lo = d; sf_p = 1; end
         else begin
           m_sf[sf_i] = expect_rgb(sf_lo, d); v_sf[sf_i] = 1; sf_p = 0;
           if (sf_a) sf_i = (sf_i + 1) % 9;
         end
      2: begin fc_a = d[15]; fc_i = int'(d[8:0]); fc_p = 0; end
      3: if (!fc_p) begin fc_lo = d; fc_p = 1; end
         else begin
           m_fc[fc_i] = expect_rgb(fc_lo, d); v_fc[fc_i] = 1; fc_p = 0;
           if (fc_a) fc_i = (fc_i + 1) % 512;
         end
      4, 5, 6: m_max[a-4] = d[15:0];
      default: ;
    endcase
  endtask

  task automatic bread(int a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = 3'(a); reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic look(bit bank, int idx, output logic [47:0] v);
    lk_bank = bank; lk_idx = 9'(idx);
    #1 v = lk_rgb;
  endtask

  task automatic check_indices(string req);
    logic [31:0] v;
    bread(0, v); check(req, v, (32'(sf_a) << 15) | 32'(sf_i));
    bread(2, v); check(req, v, (32'(fc_a) << 15) | 32'(fc_i));
  endtask

  task automatic put_pair(int dat_a, logic [47:0] e);
    bwrite(dat_a, word_lo(e));
    bwrite(dat_a, word_hi(e));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [47:0] e, keep;
    void'($urandom(32'd20240611));
    sf_i = 0; fc_i = 0; sf_a = 0; fc_a = 0; sf_p = 0; fc_p = 0;
    for (int k = 0; k < 3; k++) m_max[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    check_indices("R10");
    check("R10 max", {gmax_red, gmax_green, gmax_blue}, 48'd0);

    // R2, R3: low word alone changes nothing, pair assembles fields
    bwrite(0, 32'h0000_0003);
    put_pair(1, 48'h1234_5678_9ABC);
    look(0, 3, keep);
    check("R2 assemble", keep, 48'h1234_5678_9ABC);
    bwrite(1, word_lo(48'hFFFF_FFFF_FFFF));
    look(0, 3, e);
    check("R3 low word no store", e, keep);
    check_indices("R3 index");
    // R7 index write drops pending low word
    bwrite(0, 32'h0000_0004);
    put_pair(1, 48'h0F0F_F0F0_5A5A);
    look(0, 4, e);
    check("R7 phase reset", e, 48'h0F0F_F0F0_5A5A);
    look(0, 3, e);
    check("R7 old slot", e, keep);

    // R5 no auto: same slot overwritten
    bwrite(2, 32'h0000_0007);
    put_pair(3, 48'h1111_2222_3333);
    put_pair(3, 48'hAAAA_BBBB_CCCC);
    look(1, 7, e);
    check("R5 overwrite", e, 48'hAAAA_BBBB_CCCC);
    check_indices("R5 stay");

    // R6 wrap and out-of-range start
    bwrite(0, 32'h0000_8008);
    put_pair(1, 48'h0102_0304_0506);
    check_indices("R6 wrap superfine");
    bwrite(0, 32'h0000_801D);
    check_indices("R6 start clip");
    bwrite(2, 32'h0000_81FF);
    put_pair(3, 48'h7777_8888_9999);
    check_indices("R6 wrap main");
    look(1, 511, e);
    check("R6 last slot", e, 48'h7777_8888_9999);
    look(0, 12, e);
    check("R12 superfine beyond depth", e, 48'd0);

    // R8 full loads in order
    bwrite(0, 32'h0000_8000);
    for (int k = 0; k < 9; k++) put_pair(1, {16'(k * 7 + 1), 16'(k * 300), 16'hF000 | 16'(k)});
    check_indices("R8 superfine count");
    for (int k = 0; k < 9; k++) begin
      look(0, k, e);
      check("R8 superfine slot", e, {16'(k * 7 + 1), 16'(k * 300), 16'hF000 | 16'(k)});
    end
    bwrite(2, 32'h0000_8000);
    for (int k = 0; k < 512; k++) put_pair(3, {16'(k * 131), 16'(~k), 16'(k << 4)});
    check_indices("R8 main count");
    for (int k = 0; k < 512; k++) begin
      look(1, k, e);
      if (e !== {16'(k * 131), 16'(~k), 16'(k << 4)})
        check(k < 256 ? "R8 fine slot" : "R8 coarse slot", e, {16'(k * 131), 16'(~k), 16'(k << 4)});
    end
    check("R8 main done", 1, 1);

    // R11 independence
    look(1, 5, keep);
    bwrite(0, 32'h0000_8002);
    put_pair(1, 48'hDEAD_BEEF_CAFE);
    look(1, 5, e);
    check("R11 main untouched", e, keep);
    check_indices("R11 index");

    // R9 max registers
    bwrite(4, 32'hABCD_FFFF);
    bwrite(5, 32'h1234_0001);
    bwrite(6, 32'hFFFF_8000);
    check("R9 outputs", {gmax_red, gmax_green, gmax_blue}, 48'hFFFF_0001_8000);
    bread(5, v); check("R9 readback", v, 32'h0000_0001);
    // R1 data register reads zero
    bread(1, v); check("R1 data read", v, 32'd0);
    bread(7, v); check("R1 spare read", v, 32'd0);

    // random mix
    for (int n = 0; n < 1500; n++) begin
      int sel;
      logic [31:0] d;
      sel = int'($urandom_range(0, 19));
      d = $urandom;
      if (sel == 0)      bwrite(0, d & 32'h0000_801F);
      else if (sel == 1) bwrite(2, d & 32'h0000_81FF);
      else if (sel < 10) bwrite(1, d);
      else if (sel < 18) bwrite(3, d);
      else               bwrite(4 + int'($urandom_range(0, 2)), d);
      if (n % 50 == 0) check_indices("R4 random index");
    end
    for (int k = 0; k < 9; k++) if (v_sf[k]) begin
      look(0, k, e); check("R2 random superfine", e, m_sf[k]);
    end
    for (int k = 0; k < 512; k++) if (v_fc[k]) begin
      look(1, k, e);
      if (e !== m_fc[k]) check("R4 random main", e, m_fc[k]);
    end
    check("R9 random max", {gmax_red, gmax_green, gmax_blue}, {m_max[0], m_max[1], m_max[2]});

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule